// File: doc/BRIEF.md
# I2C Bus Condition and Hang Monitor

This block watches the two wires of an I2C bus and turns their activity into bus-level status for a controller. It brings SCL and SDA into the clock domain through two flops each. From the synchronized lines it detects START, repeated START and STOP conditions and keeps a bus-busy indication. It tracks the position of each SCL clock within the nine-clock byte-plus-acknowledge frame, so that a START or STOP arriving partway through a byte or during the acknowledge slot is reported as a bus error.

A small counter, advanced by an external sample tick, detects a hung bus: SCL held high while SDA is stuck low. A programmable time-out counter raises a time-out when event flags stay pending for too long. NACK, ACK and arbitration-lost events come from the neighbouring transfer engine as single-cycle pulses.

All events land in sticky, write-one-to-clear flags. Each flag has its own interrupt enable, and the enabled flags are combined into one registered interrupt. The hang indication stands apart: it has no flag slot and no interrupt.

Top module: `i2c_bus_monitor`

## Requirements
- R1: After reset `bus_busy`, `bus_hang`, `irq` and every flag are 0. A START (synchronized SDA falling while synchronized SCL is high) sets flag bit 0 and sets `bus_busy`.
- R2: A STOP (synchronized SDA rising while synchronized SCL is high) sets flag bit 1 and clears `bus_busy`.
- R3: While busy, the frame position counts SCL rising edges from 0 after a condition up to 9, and returns to 0 on the SCL falling edge that ends the ninth clock. After a full nine-clock frame, a STOP during the first SCL high phase of the next frame is not an error.
- R4: A START or STOP seen while busy at frame position 2 to 9 (inside a byte or its acknowledge slot) sets flag bit 5 (bus error). A condition at position 0 or 1, or while idle, does not.
- R5: A repeated START while busy at frame position 1 sets flag bit 0, keeps `bus_busy` high and raises no bus error.
- R6: A 4-bit hang counter advances on each `samp_tick` while synchronized SCL is high and resets on every SCL falling edge. When it wraps past 15 on a tick while SDA is low, `bus_hang` rises; 15 ticks are not enough.
- R7: `bus_hang` is cleared by the next START only (a STOP leaves it set) and never drives `irq`.
- R8: Single-cycle pulses on `nack_evt`, `ack_evt` and `arb_lost_evt` set flag bits 2, 3 and 4 respectively.
- R9: With `to_limit` > 0, a counter counts clock cycles while any flag is set and sets flag bit 6 (time-out) exactly `to_limit` cycles after the flags first become non-zero. It restarts when all flags are clear. `to_limit` = 0 disables the time-out.
- R10: A 1 in bit i of `flag_clr` clears flag bit i; a set event for the same bit in the same cycle wins over the clear.
- R11: `irq` is the OR of `flags & irq_en`, registered one cycle after the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| samp_tick | input | 1 | Sample tick that advances the hang counter |
| to_limit | input | TO_W (10) | Time-out length in clock cycles, 0 disables |
| irq_en | input | NFLAG (7) | Per-flag interrupt enables |
| flag_clr | input | NFLAG (7) | Write-one-to-clear pulses, one per flag |
| nack_evt | input | 1 | NACK received pulse |
| ack_evt | input | 1 | ACK received pulse |
| arb_lost_evt | input | 1 | Arbitration lost pulse |
| flags | output | NFLAG (7) | Sticky flags: 0 start, 1 stop, 2 nack, 3 ack, 4 arb lost, 5 bus error, 6 time-out |
| bus_busy | output | 1 | Bus busy between START and STOP |
| bus_hang | output | 1 | Bus hang detected |
| irq | output | 1 | Combined interrupt |

## Verification
The bench targets the frame-position boundary. A repeated START or a STOP in the first high phase after the acknowledge must pass silently, while a STOP four clocks into a byte must raise a bus error; an off-by-one counter would flag the legal case or miss the illegal one. For the hang counter it checks the gap between 15 and 16 ticks and shows that an SCL falling edge restarts the count, that a STOP leaves the hang indication set and that the interrupt stays low. The time-out is checked on the exact cycle it fires and with a zero limit, where a wrong design would fire after a wrapped count. Random event and clear pulses, including a set and a clear in the same cycle, stress the flag priority and the one-cycle interrupt delay.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;
  localparam int FLAG_NUM   = 7;
  localparam int FL_START   = 0;
  localparam int FL_STOP    = 1;
  localparam int FL_NACK    = 2;
  localparam int FL_ACK     = 3;
  localparam int FL_ARB     = 4;
  localparam int FL_BUSERR  = 5;
  localparam int FL_TIMEOUT = 6;
endpackage

// File: rtl/i2cmon_line_sync.sv
module i2cmon_line_sync (
  input  logic clk,
  input  logic rst,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int NLINES = 2;
  logic [NLINES-1:0] raw, st1, st2, prv;

  assign raw = {sda_raw, scl_raw};

  genvar g;
  generate
    for (g = 0; g < NLINES; g++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) begin
          st1[g] <= 1'b1;
          st2[g] <= 1'b1;
          prv[g] <= 1'b1;
        end else begin
          st1[g] <= raw[g];
          st2[g] <= st1[g];
          prv[g] <= st2[g];
        end
      end
    end
  endgenerate

  assign scl_lvl   = st2[0];
  assign sda_lvl   = st2[1];
  assign scl_rise  = st2[0] & ~prv[0];
  assign scl_fall  = ~st2[0] & prv[0];
  assign start_det = st2[0] & prv[0] & prv[1] & ~st2[1];
  assign stop_det  = st2[0] & prv[0] & ~prv[1] & st2[1];

  AST_NO_COND_CLASH: assert property (@(posedge clk) disable iff (rst)
    !(start_det && stop_det)); // R1
endmodule

// File: rtl/i2cmon_frame_track.sv
module i2cmon_frame_track #(
  parameter int FRAME_BITS = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic start_det,
  input  logic stop_det,
  input  logic scl_rise,
  input  logic scl_fall,
  output logic busy,
  output logic err_evt
);
  localparam int CW = $clog2(FRAME_BITS + 1);
  localparam logic [CW-1:0] LAST = CW'(FRAME_BITS);
  localparam logic [CW-1:0] FIRST_OK = CW'(1);

  logic [CW-1:0] pos;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      pos  <= '0;
    end else begin
      if (start_det) begin
        busy <= 1'b1;
        pos  <= '0;
      end else if (stop_det) begin
        busy <= 1'b0;
        pos  <= '0;
      end else if (busy) begin
        if (scl_rise && pos != LAST)
          pos <= pos + 1'b1;
        else if (scl_fall && pos == LAST)
          pos <= '0;
      end
    end
  end

  assign err_evt = (start_det | stop_det) & busy & (pos > FIRST_OK);

  AST_POS_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    pos <= LAST); // R3
  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    start_det |=> busy); // R1
  AST_IDLE_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
    (stop_det && !start_det) |=> !busy); // R2
  AST_ERR_NEEDS_COND: assert property (@(posedge clk) disable iff (rst)
    err_evt |-> (start_det || stop_det)); // R4
endmodule

// File: rtl/i2cmon_hang_det.sv
module i2cmon_hang_det #(
  parameter int HANG_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic scl_lvl,
  input  logic sda_lvl,
  input  logic scl_fall,
  input  logic start_det,
  output logic hang
);
  localparam logic [HANG_W-1:0] TOP = '1;
  logic [HANG_W-1:0] hcnt;
  logic wrap;

  assign wrap = tick & scl_lvl & (hcnt == TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt <= '0;
      hang <= 1'b0;
    end else begin
      if (scl_fall)
        hcnt <= '0;
      else if (tick && scl_lvl)
        hcnt <= hcnt + 1'b1;
      if (start_det)
        hang <= 1'b0;
      else if (wrap && !sda_lvl)
        hang <= 1'b1;
    end
  end

  AST_HANG_NEEDS_SDA_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(hang) |-> $past(scl_lvl && !sda_lvl && tick)); // R6
  AST_START_CLEARS_HANG: assert property (@(posedge clk) disable iff (rst)
    start_det |=> !hang); // R7
endmodule

// File: rtl/i2cmon_timeout.sv
module i2cmon_timeout #(
  parameter int TO_W = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [TO_W-1:0] limit,
  input  logic            pending,
  output logic            fire
);
  logic [TO_W-1:0] tcnt;
  logic            armed;

  assign armed = pending & (limit != '0);
  assign fire  = armed & (tcnt == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !armed)
      tcnt <= '0;
    else if (tcnt < limit)
      tcnt <= tcnt + 1'b1;
  end

  AST_FIRE_NEEDS_LIMIT: assert property (@(posedge clk) disable iff (rst)
    fire |-> (limit != '0 && pending)); // R9
endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
  import i2cmon_pkg::*;
#(
  parameter int TO_W       = 10,
  parameter int HANG_W     = 4,
  parameter int FRAME_BITS = 9,
  parameter int NFLAG      = FLAG_NUM
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic             samp_tick,
  input  logic [TO_W-1:0]  to_limit,
  input  logic [NFLAG-1:0] irq_en,
  input  logic [NFLAG-1:0] flag_clr,
  input  logic             nack_evt,
  input  logic             ack_evt,
  input  logic             arb_lost_evt,
  output logic [NFLAG-1:0] flags,
  output logic             bus_busy,
  output logic             bus_hang,
  output logic             irq
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic err_evt, to_fire;
  logic [NFLAG-1:0] set_vec;

  i2cmon_line_sync u_sync (
    .clk(clk), .rst(rst), .scl_raw(scl_in), .sda_raw(sda_in),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cmon_frame_track #(.FRAME_BITS(FRAME_BITS)) u_frame (
    .clk(clk), .rst(rst), .start_det(start_det), .stop_det(stop_det),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .busy(bus_busy), .err_evt(err_evt)
  );

  i2cmon_hang_det #(.HANG_W(HANG_W)) u_hang (
    .clk(clk), .rst(rst), .tick(samp_tick), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_fall(scl_fall), .start_det(start_det), .hang(bus_hang)
  );

  i2cmon_timeout #(.TO_W(TO_W)) u_to (
    .clk(clk), .rst(rst), .limit(to_limit), .pending(|flags), .fire(to_fire)
  );

  always_comb begin
    set_vec             = '0;
    set_vec[FL_START]   = start_det;
    set_vec[FL_STOP]    = stop_det;
    set_vec[FL_NACK]    = nack_evt;
    set_vec[FL_ACK]     = ack_evt;
    set_vec[FL_ARB]     = arb_lost_evt;
    set_vec[FL_BUSERR]  = err_evt;
    set_vec[FL_TIMEOUT] = to_fire;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= (flags & ~flag_clr) | set_vec;
      irq   <= |(flags & irq_en);
    end
  end

  genvar f;
  generate
    for (f = 0; f < NFLAG; f++) begin : g_flag_chk
      AST_CLR_WORKS: assert property (@(posedge clk) disable iff (rst)
        (flag_clr[f] && !set_vec[f]) |=> !flags[f]); // R10
      AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        set_vec[f] |=> flags[f]); // R10
    end
  endgenerate

  AST_IRQ_NEEDS_ENABLED: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past((flags & irq_en) != '0)); // R11
  AST_TO_NEEDS_LIMIT: assert property (@(posedge clk) disable iff (rst)
    $rose(flags[FL_TIMEOUT]) |-> $past(to_limit != '0)); // R9
endmodule

// File: tb/test_i2c_bus_monitor.sv
module test_i2c_bus_monitor;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1, sda = 1'b1, tick = 1'b0;
  logic [9:0] lim = '0;
  logic [6:0] en = '0, clr = '0;
  logic nack = 1'b0, ack = 1'b0, arb = 1'b0;
  logic [6:0] flags;
  logic busy, hang, irq;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  i2c_bus_monitor i_i2c_bus_monitor (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda), .samp_tick(tick),
    .to_limit(lim), .irq_en(en), .flag_clr(clr), .nack_evt(nack), .ack_evt(ack),
    .arb_lost_evt(arb), .flags(flags), .bus_busy(busy), .bus_hang(hang), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp_v);
    n_run++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic lines(input logic c, input logic d);
    scl = c; sda = d;
    repeat (5) @(negedge clk);
  endtask

  task automatic clear_all();
    clr = '1; @(negedge clk); clr = '0; @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    lines(1'b0, b); lines(1'b1, b); lines(1'b0, b);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; @(negedge clk); tick = 1'b0; @(negedge clk);
    end
  endtask

  function automatic logic [6:0] next_flags(input logic [6:0] cur, input logic [6:0] s,
                                            input logic [6:0] c);
    return (cur & ~c) | s;
  endfunction

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [6:0] model, prev, s, c;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset flags", flags, 0);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset hang", hang, 0);
    chk("R11 reset irq", irq, 0);

    // START from idle
    lines(1, 0);
    chk("R1 start flag", flags[0], 1);
    chk("R1 busy", busy, 1);
    chk("R4 idle start no err", flags[5], 0);
    clear_all();
    chk("R10 clear all", flags, 0);

    // full frame then repeated START at position 1
    for (int i = 0; i < 9; i++) send_bit(i[0]);
    lines(0, 1); lines(1, 1); lines(1, 0);
    chk("R5 rep start flag", flags[0], 1);
    chk("R5 busy kept", busy, 1);
    chk("R4 rep start no err", flags[5], 0);
    clear_all();

    // STOP four clocks into a byte: misplaced
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    lines(0, 0); lines(1, 0); lines(1, 1);
    chk("R4 mid-byte stop err", flags[5], 1);
    chk("R2 stop flag", flags[1], 1);
    chk("R2 busy cleared", busy, 0);
    clear_all();

    // legal STOP after full frame
    lines(1, 0);
    for (int i = 0; i < 9; i++) send_bit(1'b0);
    lines(0, 0); lines(1, 0); lines(1, 1);
    chk("R3 frame stop flag", flags[1], 1);
    chk("R3 frame stop no err", flags[5], 0);
    chk("R2 idle after stop", busy, 0);
    clear_all();

    // hang: SCL high, SDA low
    lines(1, 0);
    lines(0, 0); lines(1, 0);
    clear_all();
    en = '1;
    ticks(15);
    chk("R6 15 ticks no hang", hang, 0);
    ticks(1);
    chk("R6 16 ticks hang", hang, 1);
    chk("R7 hang no irq", irq, 0);
    lines(1, 1);
    chk("R7 stop keeps hang", hang, 1);
    lines(1, 0);
    chk("R7 start clears hang", hang, 0);
    en = '0;

    // hang counter restarted by SCL falling edge
    lines(0, 0); lines(1, 0);
    ticks(10);
    lines(0, 0); lines(1, 0);
    ticks(10);
    chk("R6 fall restarts count", hang, 0);
    lines(0, 1); lines(1, 1);
    clear_all();

    // time-out exact cycle
    lim = 10'd5;
    ack = 1'b1; @(negedge clk); ack = 1'b0;
    chk("R8 ack flag", flags[3], 1);
    repeat (4) @(negedge clk);
    chk("R9 not yet", flags[6], 0);
    @(negedge clk);
    chk("R9 timeout fires", flags[6], 1);
    clear_all();
    repeat (10) @(negedge clk);
    chk("R9 no pending no timeout", flags[6], 0);
    lim = '0;
    ack = 1'b1; @(negedge clk); ack = 1'b0;
    repeat (1100) @(negedge clk);
    chk("R9 zero limit disabled", flags[6], 0);
    clear_all();

    // set wins over clear
    nack = 1'b1; clr = 7'b0000100; @(negedge clk);
    nack = 1'b0; clr = '0;
    chk("R10 set wins", flags[2], 1);
    clear_all();

    // random event/clear/enable traffic
    model = '0;
    for (int k = 0; k < 300; k++) begin
      if (k % 50 == 0) en = 7'($urandom);
      s = '0;
      s[4:2] = 3'($urandom);
      c = 7'($urandom) & 7'($urandom);
      {arb, ack, nack} = s[4:2];
      clr = c;
      prev = model;
      model = next_flags(model, s, c);
      @(negedge clk);
      chk("R8 R10 random flags", flags, model);
      chk("R11 random irq", irq, |(prev & en));
    end
    {arb, ack, nack} = '0; clr = '0;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule